// File: doc/BRIEF.md
# Data Access Permission Check and Fault Capture Unit

This unit judges one data memory access whose translation lookup has already run. It takes the virtual address, the access size, the load/store direction, the current privilege mode, a superpage indication, the lookup hit flag and the permission bits of the matching entry. From these it yields either a physical address or a fault class with its trap vector and a six-bit status flag set. The checks run in a fixed order, and the first one that fails decides the outcome.

When a fault is reported, three capture registers are written: the faulting virtual address, a status word, and a formatted address that points into the virtual page table. No write takes place when the access is speculative, is a page-table-entry load, or is marked no-fault. In those cases the registers keep their values and do not wait to be read. Four counters track read and write access violations and misses.

A two-state machine controls the flow. In `ST_IDLE` the unit accepts a request (transition `ACCEPT`) and moves to `ST_REPORT`. There it presents the registered result for exactly one cycle, then always returns to `ST_IDLE` (transition `RETIRE`). A request presented while in `ST_REPORT` is ignored.

Top module: `dtlbchk_top`

## Requirements
- R1: After reset the unit is in `ST_IDLE`. At reset `rsp_valid_o`, the three capture registers and all four counters are zero.
- R2: A request with `req_i` high in `ST_IDLE` is accepted. Its result appears with `rsp_valid_o` high on the next cycle, for that one cycle only. A request presented while `rsp_valid_o` is high is ignored and produces no response and no counter change.
- R3: Alignment is checked first. When `va_i & (size_i-1)` is nonzero, the class is ALIGN (code 1). The flags hold only the write bit (bit 0), which is set on a store. `size_i` is 1, 2, 4 or 8.
- R4: An address whose bits 63..42 are not all equal gives class PAGE (code 2). Its flags are bad-address (bit 5) and access-violation (bit 1), plus the write bit on a store.
- R5: A superpage access when `mode_i` is not 0 (kernel) gives class ACV (code 3), with the access-violation flag plus the write bit on a store. In kernel mode there is no fault, and `paddr_o` is `va_i[PA_W-1:0]`.
- R6: A lookup miss sets the miss flag (bit 4), plus the write bit on a store. The class is PTE_MISS (code 5) when `pte_load_i` is set, and MISS (code 4) otherwise.
- R7: A store whose `wr_en_i[mode_i]` is clear gives PAGE with the write and access-violation bits, plus fault-on-write (bit 3) if `fonw_i` is set. A store that passes that check but has `fonw_i` set gives PAGE with the write and fault-on-write bits.
- R8: A load whose `rd_en_i[mode_i]` is clear gives ACV with the access-violation bit, plus fault-on-read (bit 2) if `fonr_i` is set. A load that passes that check but has `fonr_i` set gives PAGE with only the fault-on-read bit.
- R9: An access that raises no fault has class NONE (code 0) and vector 0. Through the table, `paddr_o` is `{pfn_i, va_i[12:0]}` for the default 8 KiB page. On any fault `paddr_o` is 0.
- R10: A captured fault writes three registers. `fault_va_o` gets `va_i`. `fault_stat_o` gets `opcode_i<<11 | ra_i<<6 | flags`. `fault_vform_o` gets `vptbr_i | (va_i>>13)<<3`.
- R11: The capture registers are left unchanged when there is no fault, or when any of `spec_i`, `pte_load_i` or `no_fault_i` is set.
- R12: The vectors are 0x0301 for ALIGN, 0x0381 for ACV, 0x0281 for PAGE, 0x0201 for MISS and 0x0101 for PTE_MISS.
- R13: The counters respond to fault classes as follows. PAGE and ACV advance the read or write violation counter, MISS and PTE_MISS advance the read or write miss counter, and each counter adds one per such response. ALIGN and NONE leave all four unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access to judge |
| va_i | input | 64 | Virtual address |
| size_i | input | 4 | Access size in bytes |
| write_i | input | 1 | 1 = store |
| mode_i | input | 2 | Privilege mode, 0 = kernel |
| superpage_i | input | 1 | Address lies in a superpage region |
| hit_i | input | 1 | Lookup found an entry |
| pfn_i | input | PFN_W (31) | Page frame number of the entry |
| rd_en_i | input | 4 | Read enable per mode |
| wr_en_i | input | 4 | Write enable per mode |
| fonr_i | input | 1 | Entry fault-on-read |
| fonw_i | input | 1 | Entry fault-on-write |
| opcode_i | input | 6 | Instruction opcode field |
| ra_i | input | 5 | Instruction register field |
| pte_load_i | input | 1 | Access is a page-table-entry load |
| no_fault_i | input | 1 | Access is marked no-fault |
| spec_i | input | 1 | Access is speculative |
| vptbr_i | input | 64 | Virtual page table base |
| rsp_valid_o | output | 1 | Result valid (state `ST_REPORT`) |
| fclass_o | output | 3 | Fault class code |
| fflags_o | output | 6 | Status flags of this result |
| vector_o | output | 16 | Trap vector |
| paddr_o | output | PA_W (44) | Physical address |
| fault_va_o | output | 64 | Captured virtual address |
| fault_stat_o | output | 17 | Captured status word |
| fault_vform_o | output | 64 | Captured formatted address |
| rd_acv_cnt_o | output | CNT_W (16) | Read violation count |
| wr_acv_cnt_o | output | CNT_W (16) | Write violation count |
| rd_miss_cnt_o | output | CNT_W (16) | Read miss count |
| wr_miss_cnt_o | output | CNT_W (16) | Write miss count |

## Verification
The assertions assume that `size_i` is always a power of two no larger than 8 and that inputs are steady around each sampling edge. The alignment and vector properties rely on a well-formed size, because a zero size would make the mask all ones. The random stimulus picks the size only from {1, 2, 4, 8}. It biases addresses toward sign-extended, aligned values so that every later check in the priority chain is reached, and a few directed cases target each class and the suppression flags.

// File: rtl/dtlbchk_pkg.sv
package dtlbchk_pkg;

    typedef enum logic [2:0] {
        FC_NONE     = 3'd0,
        FC_ALIGN    = 3'd1,
        FC_PAGE     = 3'd2,
        FC_ACV      = 3'd3,
        FC_MISS     = 3'd4,
        FC_PTE_MISS = 3'd5
    } fclass_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;

    localparam int FLAG_W   = 6;
    localparam int FL_WR    = 0;
    localparam int FL_ACV   = 1;
    localparam int FL_FONR  = 2;
    localparam int FL_FONW  = 3;
    localparam int FL_MISS  = 4;
    localparam int FL_BADVA = 5;

    localparam logic [1:0] MODE_KERNEL = 2'd0;

    function automatic logic [15:0] vector_of(fclass_e c);
        logic [15:0] v;
        unique case (c)
            FC_ALIGN:    v = 16'h0301;
            FC_ACV:      v = 16'h0381;
            FC_PAGE:     v = 16'h0281;
            FC_MISS:     v = 16'h0201;
            FC_PTE_MISS: v = 16'h0101;
            default:     v = 16'h0000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dtlbchk_judge.sv
module dtlbchk_judge
    import dtlbchk_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int VALID_BITS = 43,
    parameter int PA_W       = 44,
    parameter int PG_SHIFT   = 13,
    parameter int MODE_W     = 2,
    localparam int PFN_W     = PA_W - PG_SHIFT,
    localparam int NMODE     = 1 << MODE_W
) (
    input  logic [VA_W-1:0]   va,
    input  logic [3:0]        size,
    input  logic              wr,
    input  logic [MODE_W-1:0] mode,
    input  logic              sp,
    input  logic              hit,
    input  logic [PFN_W-1:0]  pfn,
    input  logic [NMODE-1:0]  re,
    input  logic [NMODE-1:0]  we,
    input  logic              fonr,
    input  logic              fonw,
    input  logic              pte_load,
    output fclass_e           cls,
    output logic [FLAG_W-1:0] flags,
    output logic [PA_W-1:0]   paddr
);
    logic va_ok;
    logic misaligned;

    assign va_ok      = (&va[VA_W-1:VALID_BITS-1]) | ~(|va[VA_W-1:VALID_BITS-1]);
    assign misaligned = |(va[3:0] & (size - 4'd1));

    always_comb begin
        cls   = FC_NONE;
        flags = '0;
        paddr = '0;
        if (misaligned) begin
            cls          = FC_ALIGN;
            flags[FL_WR] = wr;
        end else if (!va_ok) begin
            cls             = FC_PAGE;
            flags[FL_WR]    = wr;
            flags[FL_ACV]   = 1'b1;
            flags[FL_BADVA] = 1'b1;
        end else if (sp) begin
            if (mode != MODE_KERNEL) begin
                cls           = FC_ACV;
                flags[FL_WR]  = wr;
                flags[FL_ACV] = 1'b1;
            end else begin
                paddr = va[PA_W-1:0];
            end
        end else if (!hit) begin
            cls            = pte_load ? FC_PTE_MISS : FC_MISS;
            flags[FL_WR]   = wr;
            flags[FL_MISS] = 1'b1;
        end else if (wr) begin
            if (!we[mode]) begin
                cls            = FC_PAGE;
                flags[FL_WR]   = 1'b1;
                flags[FL_ACV]  = 1'b1;
                flags[FL_FONW] = fonw;
            end else if (fonw) begin
                cls            = FC_PAGE;
                flags[FL_WR]   = 1'b1;
                flags[FL_FONW] = 1'b1;
            end else begin
                paddr = {pfn, va[PG_SHIFT-1:0]};
            end
        end else begin
            if (!re[mode]) begin
                cls            = FC_ACV;
                flags[FL_ACV]  = 1'b1;
                flags[FL_FONR] = fonr;
            end else if (fonr) begin
                cls            = FC_PAGE;
                flags[FL_FONR] = 1'b1;
            end else begin
                paddr = {pfn, va[PG_SHIFT-1:0]};
            end
        end
    end
endmodule

// File: rtl/dtlbchk_capture.sv
module dtlbchk_capture
    import dtlbchk_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PG_SHIFT = 13,
    localparam int STAT_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [VA_W-1:0]   va,
    input  logic [5:0]        opcode,
    input  logic [4:0]        ra,
    input  logic [FLAG_W-1:0] flags,
    input  logic [VA_W-1:0]   vptbr,
    output logic [VA_W-1:0]   fault_va,
    output logic [STAT_W-1:0] fault_stat,
    output logic [VA_W-1:0]   fault_vform
);
    logic [VA_W-1:0] vpn;
    assign vpn = va >> PG_SHIFT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_va    <= '0;
            fault_stat  <= '0;
            fault_vform <= '0;
        end else if (cap_en) begin
            fault_va    <= va;
            fault_stat  <= ({11'd0, opcode} << 11) | ({12'd0, ra} << 6) | {11'd0, flags};
            fault_vform <= vptbr | (vpn << 3);
        end
    end

    // R11: without a capture request the registers keep their value
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(fault_va) && $stable(fault_stat) && $stable(fault_vform)));

    // R10: a capture records the address presented
    p_take_va_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (fault_va == $past(va)));
endmodule

// File: rtl/dtlbchk_counters.sv
module dtlbchk_counters #(
    parameter int NCNT  = 4,
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCNT-1:0]            inc,
    output logic [NCNT-1:0][CNT_W-1:0] cnt
);
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[g] <= '0;
            else if (inc[g])
                cnt[g] <= cnt[g] + 1'b1;
        end

        // R13: a counter moves only on its own event
        p_cnt_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
            !inc[g] |=> $stable(cnt[g]));
    end
endmodule

// File: rtl/dtlbchk_top.sv
module dtlbchk_top
    import dtlbchk_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int VALID_BITS = 43,
    parameter int PA_W       = 44,
    parameter int PAGE_BYTES = 8192,
    parameter int CNT_W      = 16,
    localparam int PG_SHIFT  = $clog2(PAGE_BYTES),
    localparam int PFN_W     = PA_W - PG_SHIFT,
    localparam int MODE_W    = 2,
    localparam int NMODE     = 1 << MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic [3:0]        size_i,
    input  logic              write_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              superpage_i,
    input  logic              hit_i,
    input  logic [PFN_W-1:0]  pfn_i,
    input  logic [NMODE-1:0]  rd_en_i,
    input  logic [NMODE-1:0]  wr_en_i,
    input  logic              fonr_i,
    input  logic              fonw_i,
    input  logic [5:0]        opcode_i,
    input  logic [4:0]        ra_i,
    input  logic              pte_load_i,
    input  logic              no_fault_i,
    input  logic              spec_i,
    input  logic [VA_W-1:0]   vptbr_i,
    output logic              rsp_valid_o,
    output logic [2:0]        fclass_o,
    output logic [5:0]        fflags_o,
    output logic [15:0]       vector_o,
    output logic [PA_W-1:0]   paddr_o,
    output logic [VA_W-1:0]   fault_va_o,
    output logic [16:0]       fault_stat_o,
    output logic [VA_W-1:0]   fault_vform_o,
    output logic [CNT_W-1:0]  rd_acv_cnt_o,
    output logic [CNT_W-1:0]  wr_acv_cnt_o,
    output logic [CNT_W-1:0]  rd_miss_cnt_o,
    output logic [CNT_W-1:0]  wr_miss_cnt_o
);
    state_e            state_q, state_d;
    fclass_e           cls, cls_q;
    logic [FLAG_W-1:0] flags, flags_q;
    logic [PA_W-1:0]   paddr, paddr_q;
    logic              accept;
    logic              cap_en;
    logic              is_viol, is_miss;
    logic [3:0]        inc;
    logic [3:0][CNT_W-1:0] cnt;

    dtlbchk_judge #(
        .VA_W(VA_W), .VALID_BITS(VALID_BITS), .PA_W(PA_W),
        .PG_SHIFT(PG_SHIFT), .MODE_W(MODE_W)
    ) judge_i (
        .va(va_i), .size(size_i), .wr(write_i), .mode(mode_i),
        .sp(superpage_i), .hit(hit_i), .pfn(pfn_i),
        .re(rd_en_i), .we(wr_en_i), .fonr(fonr_i), .fonw(fonw_i),
        .pte_load(pte_load_i), .cls(cls), .flags(flags), .paddr(paddr)
    );

    // next-state logic: ACCEPT and RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign accept = (state_q == ST_IDLE) && req_i;

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q   <= FC_NONE;
            flags_q <= '0;
            paddr_q <= '0;
        end else if (accept) begin
            cls_q   <= cls;
            flags_q <= flags;
            paddr_q <= paddr;
        end
    end

    assign rsp_valid_o = (state_q == ST_REPORT);
    assign fclass_o    = cls_q;
    assign fflags_o    = flags_q;
    assign vector_o    = vector_of(cls_q);
    assign paddr_o     = paddr_q;

    assign cap_en = accept && (cls != FC_NONE) && !spec_i && !pte_load_i && !no_fault_i;

    dtlbchk_capture #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT)) capture_i (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .va(va_i),
        .opcode(opcode_i), .ra(ra_i), .flags(flags), .vptbr(vptbr_i),
        .fault_va(fault_va_o), .fault_stat(fault_stat_o), .fault_vform(fault_vform_o)
    );

    assign is_viol = (cls == FC_PAGE) || (cls == FC_ACV);
    assign is_miss = (cls == FC_MISS) || (cls == FC_PTE_MISS);
    assign inc = {accept & is_miss & write_i, accept & is_miss & ~write_i,
                  accept & is_viol & write_i, accept & is_viol & ~write_i};

    dtlbchk_counters #(.NCNT(4), .CNT_W(CNT_W)) counters_i (
        .clk(clk), .rst_n(rst_n), .inc(inc), .cnt(cnt)
    );

    assign rd_acv_cnt_o  = cnt[0];
    assign wr_acv_cnt_o  = cnt[1];
    assign rd_miss_cnt_o = cnt[2];
    assign wr_miss_cnt_o = cnt[3];

    p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !rsp_valid_o) |=> rsp_valid_o);

    p_align_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && fclass_o == 3'd1) |-> (vector_o == 16'h0301));

    p_acv_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && fclass_o == 3'd3) |-> (vector_o == 16'h0381));

    p_align_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && fclass_o == 3'd1) |-> (fflags_o[5:1] == 5'd0));

    p_fault_nopa_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && fclass_o != 3'd0) |-> (paddr_o == '0));

    p_miss_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && (fclass_o == 3'd4 || fclass_o == 3'd5)) |-> fflags_o[4]);
endmodule

// File: tb/dtlbchk_top_tb_top.sv
module dtlbchk_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [63:0] va_i = '0;
    logic [3:0]  size_i = 4'd1;
    logic        write_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic        superpage_i = 1'b0;
    logic        hit_i = 1'b0;
    logic [30:0] pfn_i = '0;
    logic [3:0]  rd_en_i = '0;
    logic [3:0]  wr_en_i = '0;
    logic        fonr_i = 1'b0;
    logic        fonw_i = 1'b0;
    logic [5:0]  opcode_i = '0;
    logic [4:0]  ra_i = '0;
    logic        pte_load_i = 1'b0;
    logic        no_fault_i = 1'b0;
    logic        spec_i = 1'b0;
    logic [63:0] vptbr_i = '0;
    logic        rsp_valid_o;
    logic [2:0]  fclass_o;
    logic [5:0]  fflags_o;
    logic [15:0] vector_o;
    logic [43:0] paddr_o;
    logic [63:0] fault_va_o;
    logic [16:0] fault_stat_o;
    logic [63:0] fault_vform_o;
    logic [15:0] rd_acv_cnt_o, wr_acv_cnt_o, rd_miss_cnt_o, wr_miss_cnt_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [63:0] m_va, m_vform;
    logic [16:0] m_stat;
    logic [15:0] m_cnt [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dtlbchk_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .va_i(va_i), .size_i(size_i),
        .write_i(write_i), .mode_i(mode_i), .superpage_i(superpage_i), .hit_i(hit_i),
        .pfn_i(pfn_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .fonr_i(fonr_i),
        .fonw_i(fonw_i), .opcode_i(opcode_i), .ra_i(ra_i), .pte_load_i(pte_load_i),
        .no_fault_i(no_fault_i), .spec_i(spec_i), .vptbr_i(vptbr_i),
        .rsp_valid_o(rsp_valid_o), .fclass_o(fclass_o), .fflags_o(fflags_o),
        .vector_o(vector_o), .paddr_o(paddr_o), .fault_va_o(fault_va_o),
        .fault_stat_o(fault_stat_o), .fault_vform_o(fault_vform_o),
        .rd_acv_cnt_o(rd_acv_cnt_o), .wr_acv_cnt_o(wr_acv_cnt_o),
        .rd_miss_cnt_o(rd_miss_cnt_o), .wr_miss_cnt_o(wr_miss_cnt_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // expected result from the requirements
    task automatic ref_judge(output logic [2:0] cls, output logic [5:0] fl,
                             output logic [43:0] pa, output string tag);
        logic [21:0] top;
        top = va_i[63:42];
        cls = 3'd0; fl = '0; pa = '0; tag = "R9";
        if ((va_i[3:0] & (size_i - 4'd1)) != 4'd0) begin
            cls = 3'd1; fl = {5'd0, write_i}; tag = "R3";
        end else if (!(top == '0 || top == '1)) begin
            cls = 3'd2; fl = 6'b100010 | {5'd0, write_i}; tag = "R4";
        end else if (superpage_i) begin
            tag = "R5";
            if (mode_i != 2'd0) begin cls = 3'd3; fl = 6'b000010 | {5'd0, write_i}; end
            else pa = va_i[43:0];
        end else if (!hit_i) begin
            cls = pte_load_i ? 3'd5 : 3'd4; fl = 6'b010000 | {5'd0, write_i}; tag = "R6";
        end else if (write_i) begin
            tag = "R7";
            if (!wr_en_i[mode_i]) begin cls = 3'd2; fl = {2'b00, fonw_i, 3'b011}; end
            else if (fonw_i) begin cls = 3'd2; fl = 6'b001001; end
            else begin pa = {pfn_i, va_i[12:0]}; tag = "R9"; end
        end else begin
            tag = "R8";
            if (!rd_en_i[mode_i]) begin cls = 3'd3; fl = {3'b000, fonr_i, 2'b10}; end
            else if (fonr_i) begin cls = 3'd2; fl = 6'b000100; end
            else begin pa = {pfn_i, va_i[12:0]}; tag = "R9"; end
        end
    endtask

    function automatic logic [15:0] ref_vec(input logic [2:0] c);
        case (c)
            3'd1: return 16'h0301;
            3'd2: return 16'h0281;
            3'd3: return 16'h0381;
            3'd4: return 16'h0201;
            3'd5: return 16'h0101;
            default: return 16'h0000;
        endcase
    endfunction

    // one access: drive at negedge, accepted at posedge, sampled next negedge
    task automatic access();
        logic [2:0]  e_cls;
        logic [5:0]  e_fl;
        logic [43:0] e_pa;
        string       tag;
        ref_judge(e_cls, e_fl, e_pa, tag);
        if (e_cls != 3'd0 && !spec_i && !pte_load_i && !no_fault_i) begin
            m_va    = va_i;
            m_stat  = {opcode_i, ra_i, e_fl};
            m_vform = vptbr_i | ((va_i >> 13) << 3);
        end
        if (e_cls == 3'd2 || e_cls == 3'd3) m_cnt[write_i ? 1 : 0]++;
        if (e_cls == 3'd4 || e_cls == 3'd5) m_cnt[write_i ? 3 : 2]++;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        chk(rsp_valid_o == 1'b1, "R2", "rsp_valid", {63'd0, rsp_valid_o}, 64'd1);
        chk(fclass_o == e_cls && fflags_o == e_fl, tag, "class/flags",
            {55'd0, fclass_o, fflags_o}, {55'd0, e_cls, e_fl});
        chk(vector_o == ref_vec(e_cls), "R12", "vector", {48'd0, vector_o}, {48'd0, ref_vec(e_cls)});
        chk(paddr_o == e_pa, (tag == "R5") ? "R5" : "R9", "paddr", {20'd0, paddr_o}, {20'd0, e_pa});
        chk(fault_va_o == m_va && fault_stat_o == m_stat && fault_vform_o == m_vform,
            (spec_i || pte_load_i || no_fault_i || e_cls == 3'd0) ? "R11" : "R10",
            "capture va/stat", fault_va_o ^ {47'd0, fault_stat_o}, m_va ^ {47'd0, m_stat});
        chk(fault_vform_o == m_vform, "R10", "vform", fault_vform_o, m_vform);
        chk(rd_acv_cnt_o == m_cnt[0] && wr_acv_cnt_o == m_cnt[1] &&
            rd_miss_cnt_o == m_cnt[2] && wr_miss_cnt_o == m_cnt[3], "R13", "counters",
            {rd_acv_cnt_o, wr_acv_cnt_o, rd_miss_cnt_o, wr_miss_cnt_o},
            {m_cnt[0], m_cnt[1], m_cnt[2], m_cnt[3]});
        @(negedge clk);
        chk(rsp_valid_o == 1'b0, "R2", "valid drops", {63'd0, rsp_valid_o}, 64'd0);
    endtask

    task automatic set_plain(input logic [63:0] va, input logic [3:0] sz, input logic wr);
        va_i = va; size_i = sz; write_i = wr; mode_i = 2'd1; superpage_i = 1'b0;
        hit_i = 1'b1; pfn_i = 31'h12345; rd_en_i = 4'hF; wr_en_i = 4'hF;
        fonr_i = 1'b0; fonw_i = 1'b0; pte_load_i = 1'b0; no_fault_i = 1'b0; spec_i = 1'b0;
        opcode_i = 6'h2C; ra_i = 5'h11; vptbr_i = 64'hFFFF_FE00_0000_0000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        m_va = '0; m_stat = '0; m_vform = '0;
        for (int i = 0; i < 4; i++) m_cnt[i] = '0;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rsp_valid_o == 1'b0, "R1", "valid", {63'd0, rsp_valid_o}, 64'd0);
        chk(fault_va_o == '0 && fault_stat_o == '0 && fault_vform_o == '0, "R1", "capture",
            fault_va_o | fault_vform_o, 64'd0);
        chk({rd_acv_cnt_o, wr_acv_cnt_o, rd_miss_cnt_o, wr_miss_cnt_o} == '0, "R1", "counters",
            {rd_acv_cnt_o, wr_acv_cnt_o, rd_miss_cnt_o, wr_miss_cnt_o}, 64'd0);

        // directed corners
        set_plain(64'h0000_0000_0012_3456, 4'd4, 1'b1); access();           // R3 store misaligned
        set_plain(64'h0000_0000_0012_3451, 4'd1, 1'b0); access();           // byte never misaligned, R9
        set_plain(64'h0100_0000_0000_0000, 4'd8, 1'b1); access();           // R4 bad address
        set_plain(64'hFFFF_FC00_0000_1008, 4'd8, 1'b0); superpage_i = 1'b1; access(); // R5 user
        set_plain(64'hFFFF_FC80_1234_5678, 4'd8, 1'b0); superpage_i = 1'b1; mode_i = 2'd0; access(); // R5 kernel
        set_plain(64'h0000_0000_4000_2000, 4'd8, 1'b0); hit_i = 1'b0; access(); // R6 miss
        set_plain(64'h0000_0000_4000_2000, 4'd8, 1'b1); hit_i = 1'b0; pte_load_i = 1'b1; access(); // R6 pte, R11
        set_plain(64'h0000_0000_0000_8000, 4'd8, 1'b1); wr_en_i = 4'hD; fonw_i = 1'b1; access(); // R7
        set_plain(64'h0000_0000_0000_8000, 4'd8, 1'b1); fonw_i = 1'b1; access(); // R7 fonw only
        set_plain(64'h0000_0000_0000_8000, 4'd8, 1'b0); rd_en_i = 4'hD; fonr_i = 1'b1; access(); // R8
        set_plain(64'h0000_0000_0000_8000, 4'd8, 1'b0); fonr_i = 1'b1; access(); // R8 fonr only
        set_plain(64'h0000_0000_0000_9001, 4'd2, 1'b0); spec_i = 1'b1; access(); // R11 speculative
        set_plain(64'h0000_0000_0000_9001, 4'd2, 1'b1); no_fault_i = 1'b1; access(); // R11 no-fault

        // R2: request held during the report cycle is ignored
        set_plain(64'h0000_0000_0000_8000, 4'd8, 1'b0); hit_i = 1'b0;
        m_cnt[2]++;
        req_i = 1'b1;
        @(negedge clk);
        chk(rsp_valid_o == 1'b1, "R2", "first response", {63'd0, rsp_valid_o}, 64'd1);
        @(negedge clk);
        req_i = 1'b0;
        chk(rsp_valid_o == 1'b0, "R2", "ignored in report", {63'd0, rsp_valid_o}, 64'd0);
        chk(rd_miss_cnt_o == m_cnt[2], "R2", "no extra count", {48'd0, rd_miss_cnt_o}, {48'd0, m_cnt[2]});

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] v;
            logic [1:0]  szsel;
            v = {$urandom, $urandom};
            if ($urandom_range(0, 7) != 0) v[63:42] = {22{v[42]}};
            szsel = 2'($urandom_range(0, 3));
            size_i = 4'd1 << szsel;
            if ($urandom_range(0, 3) != 0) v[2:0] = 3'd0;
            va_i = v;
            write_i = 1'($urandom_range(0, 1));
            mode_i = 2'($urandom_range(0, 3));
            superpage_i = ($urandom_range(0, 7) == 0);
            hit_i = ($urandom_range(0, 7) != 0);
            pfn_i = 31'($urandom);
            rd_en_i = 4'($urandom) | 4'($urandom);
            wr_en_i = 4'($urandom) | 4'($urandom);
            fonr_i = ($urandom_range(0, 3) == 0);
            fonw_i = ($urandom_range(0, 3) == 0);
            opcode_i = 6'($urandom);
            ra_i = 5'($urandom);
            pte_load_i = ($urandom_range(0, 7) == 0);
            no_fault_i = ($urandom_range(0, 7) == 0);
            spec_i = ($urandom_range(0, 7) == 0);
            vptbr_i = {$urandom, $urandom} & 64'hFFFF_FFFF_C000_0000;
            access();
        end
        summary();
    end
endmodule